// File: doc/BRIEF.md
# Suspend and Shutdown Power Controller

This controller sits between two board-level control pins and the clock generation core of a multi-PLL clock chip. One pin is an active-low output-enable that can also be configured as a full power-down request. The other pin is shared: it is normally the third frequency-select bit, but it can be reconfigured as an active-low suspend request. The controller produces a drive-enable for each routed clock output and for the buffered reference output. It also produces run-enables for each PLL, for the reference oscillator and for the divider counters.

Suspend acts on a configured set of PLLs and a configured set of outputs. Each routed output has a source code, where 0 means the reference and k means PLL k-1. An output whose source PLL is in the suspend set is added to the suspended outputs even when its own mask bit is clear, and a configuration-error flag reports that this correction is taking place. Whenever a PLL restarts after a full shutdown or a suspend, the outputs it feeds stay tristated for a programmable number of cycles, which stands in for relock time. Reference-sourced outputs do not wait.

Both pins are asynchronous. Each passes through a two-flop synchronizer, and all enables are registered once after that.

Top module: `pwr_susp_ctrl`

## Requirements
- R1: While the synchronized output-enable pin is low, every `out_en_o` bit and `ref_out_en_o` are 0, whatever the configuration.
- R2: With `cfg_full_shdn_i`=1, a low output-enable pin also drives `pll_en_o`, `osc_en_o` and `core_en_o` to 0.
- R3: With `cfg_full_shdn_i`=0, a low output-enable pin leaves PLLs, oscillator and counters running. After release, all outputs return on the third rising edge with no relock wait.
- R4: With `cfg_susp_en_i`=1 and the shared pin low, each PLL with its `cfg_susp_pll_i` bit set is disabled, and each output with its `cfg_susp_out_i` bit set is tristated. With `cfg_susp_en_i`=0 the pin causes no suspend.
- R5: `sel2_o` equals the synchronized shared pin when `cfg_susp_en_i`=0, and is 0 when `cfg_susp_en_i`=1.
- R6: Output o has a source code in `cfg_src_i[o*SRC_W +: SRC_W]`: 0 is the reference, and k is PLL k-1 (bit k-1 of the PLL vectors). When that code names a suspended PLL, the output is tristated during suspend even if its own mask bit is clear. `cfg_err_o` is 1, one cycle after the configuration, whenever `cfg_susp_en_i`=1 and such an uncovered output exists.
- R7: When a PLL enable rises, outputs sourced from that PLL turn on exactly `cfg_relock_i` cycles later. A value of 0 lets them turn on together with the PLL enable.
- R8: A pin change sampled at one rising edge shows on the enables after the third rising edge: two for synchronization and one for the output register.
- R9: `ref_out_en_o` follows only the output-enable pin and ignores suspend.
- R10: During reset, `out_en_o` and `ref_out_en_o` are 0, `pll_en_o` is all ones, `osc_en_o`, `core_en_o` are 1 and `cfg_err_o` is 0. Both pins are treated as deasserted, so outputs enable after the first edge following reset.
- R11: While routing is stable, no output is enabled while the PLL it is sourced from is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| shdn_oe_ni | input | 1 | Asynchronous active-low output-enable / shutdown pin |
| sel2_susp_ni | input | 1 | Asynchronous shared select bit / active-low suspend pin |
| cfg_full_shdn_i | input | 1 | 1: output-enable pin also powers down PLLs, oscillator, counters |
| cfg_susp_en_i | input | 1 | 1: shared pin acts as suspend |
| cfg_susp_pll_i | input | NUM_PLL | PLLs stopped on suspend |
| cfg_susp_out_i | input | NUM_OUT | Outputs tristated on suspend |
| cfg_src_i | input | NUM_OUT*SRC_W | Per-output source code (0 reference, k PLL k-1) |
| cfg_relock_i | input | CNT_W | Relock wait in cycles |
| out_en_o | output | NUM_OUT | Drive enable per routed output (0 = tristate) |
| ref_out_en_o | output | 1 | Drive enable of the buffered reference output |
| pll_en_o | output | NUM_PLL | Run enable per PLL |
| osc_en_o | output | 1 | Reference oscillator enable |
| core_en_o | output | 1 | Divider counter enable |
| sel2_o | output | 1 | Synchronized third select bit for frequency selection |
| cfg_err_o | output | 1 | Suspend mask needed correction |

## Verification
A table of steady configurations is walked. It covers output-enable only versus full shutdown, suspend disabled versus enabled with the pin low and high, and masks that either cover or leave uncovered the outputs of a suspended PLL. This separates pin gating, PLL gating, mask correction and the reference exemption. Directed sequences then count edges after a pin change, which separates the synchronizer latency from the relock wait, and compare a relock value of 0 with a non-zero one. A rerouting test moves an output from a suspended PLL to the reference and shows that the forced mask follows the current routing, not a fixed mapping.

// File: rtl/pwr_susp_pkg.sv
package pwr_susp_pkg;
    localparam int unsigned DEF_NUM_PLL = 3;
    localparam int unsigned DEF_NUM_OUT = 5;
    localparam int unsigned DEF_CNT_W   = 16;

    typedef enum int unsigned {
        PIN_SHDN  = 0,
        PIN_SUSP  = 1,
        PIN_COUNT = 2
    } pin_idx_e;
endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    // pins are active low, so reset presents them as deasserted
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= '1;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwr_relock_ctr.sv
module pwr_relock_ctr #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             off_d_i,
    input  logic [CNT_W-1:0] relock_i,
    output logic             ready_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (off_d_i) begin
            cnt_d = relock_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        // ready looks at the enable about to be registered, so a zero
        // wait lets outputs rise on the same edge as the PLL enable
        ready_o = !off_d_i && (cnt_q == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/pwr_route_map.sv
module pwr_route_map #(
    parameter  int unsigned NUM_PLL = 3,
    parameter  int unsigned NUM_OUT = 5,
    localparam int unsigned SRC_W   = $clog2(NUM_PLL + 1)
) (
    input  logic                     susp_en_i,
    input  logic [NUM_PLL-1:0]       susp_pll_i,
    input  logic [NUM_PLL-1:0]       pll_ready_i,
    input  logic [NUM_OUT-1:0]       susp_out_i,
    input  logic [NUM_OUT*SRC_W-1:0] src_i,
    output logic [NUM_OUT-1:0]       eff_mask_o,
    output logic [NUM_OUT-1:0]       src_ready_o,
    output logic                     forced_o
);
    logic [NUM_OUT-1:0] hit;
    logic [NUM_OUT-1:0] forced_bits;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        logic hit_b;
        logic rdy_b;
        always_comb begin
            hit_b = 1'b0;
            rdy_b = 1'b1;
            for (int p = 0; p < NUM_PLL; p++) begin
                if (src_i[o*SRC_W +: SRC_W] == SRC_W'(p + 1)) begin
                    hit_b = susp_pll_i[p];
                    rdy_b = pll_ready_i[p];
                end
            end
        end
        assign hit[o]         = hit_b;
        assign src_ready_o[o] = rdy_b;
    end

    assign eff_mask_o  = susp_out_i | hit;
    assign forced_bits = hit & ~susp_out_i;
    assign forced_o    = susp_en_i & (|forced_bits);
endmodule

// File: rtl/pwr_susp_ctrl.sv
module pwr_susp_ctrl
    import pwr_susp_pkg::*;
#(
    parameter  int unsigned NUM_PLL = DEF_NUM_PLL,
    parameter  int unsigned NUM_OUT = DEF_NUM_OUT,
    parameter  int unsigned CNT_W   = DEF_CNT_W,
    localparam int unsigned SRC_W   = $clog2(NUM_PLL + 1)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     shdn_oe_ni,
    input  logic                     sel2_susp_ni,
    input  logic                     cfg_full_shdn_i,
    input  logic                     cfg_susp_en_i,
    input  logic [NUM_PLL-1:0]       cfg_susp_pll_i,
    input  logic [NUM_OUT-1:0]       cfg_susp_out_i,
    input  logic [NUM_OUT*SRC_W-1:0] cfg_src_i,
    input  logic [CNT_W-1:0]         cfg_relock_i,
    output logic [NUM_OUT-1:0]       out_en_o,
    output logic                     ref_out_en_o,
    output logic [NUM_PLL-1:0]       pll_en_o,
    output logic                     osc_en_o,
    output logic                     core_en_o,
    output logic                     sel2_o,
    output logic                     cfg_err_o
);
    typedef struct packed {
        logic [NUM_OUT-1:0] out_en;
        logic               ref_en;
        logic [NUM_PLL-1:0] pll_en;
        logic               osc_en;
        logic               core_en;
        logic               err;
    } state_t;

    logic [PIN_COUNT-1:0] pins_s;
    logic                 shdn_sync;
    logic                 susp_sync;
    logic                 shdn_act;
    logic                 full_off;
    logic                 susp_act;
    logic [NUM_PLL-1:0]   pll_off_d;
    logic [NUM_PLL-1:0]   pll_ready;
    logic [NUM_OUT-1:0]   eff_mask;
    logic [NUM_OUT-1:0]   src_ready;
    logic                 forced;
    state_t               st_d, st_q;

    pwr_pin_sync #(
        .W      (PIN_COUNT),
        .STAGES (2)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({sel2_susp_ni, shdn_oe_ni}),
        .sync_o  (pins_s)
    );

    assign shdn_sync = pins_s[PIN_SHDN];
    assign susp_sync = pins_s[PIN_SUSP];
    assign shdn_act  = !shdn_sync;
    assign full_off  = shdn_act && cfg_full_shdn_i;
    assign susp_act  = cfg_susp_en_i && !susp_sync;
    assign pll_off_d = {NUM_PLL{full_off}} | ({NUM_PLL{susp_act}} & cfg_susp_pll_i);

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
        pwr_relock_ctr #(
            .CNT_W (CNT_W)
        ) u_relock (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .off_d_i  (pll_off_d[p]),
            .relock_i (cfg_relock_i),
            .ready_o  (pll_ready[p])
        );
    end

    pwr_route_map #(
        .NUM_PLL (NUM_PLL),
        .NUM_OUT (NUM_OUT)
    ) u_route (
        .susp_en_i   (cfg_susp_en_i),
        .susp_pll_i  (cfg_susp_pll_i),
        .pll_ready_i (pll_ready),
        .susp_out_i  (cfg_susp_out_i),
        .src_i       (cfg_src_i),
        .eff_mask_o  (eff_mask),
        .src_ready_o (src_ready),
        .forced_o    (forced)
    );

    always_comb begin
        st_d         = st_q;
        st_d.out_en  = {NUM_OUT{!shdn_act}}
                     & ~({NUM_OUT{susp_act}} & eff_mask)
                     & src_ready;
        st_d.ref_en  = !shdn_act;
        st_d.pll_en  = ~pll_off_d;
        st_d.osc_en  = !full_off;
        st_d.core_en = !full_off;
        st_d.err     = forced;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.out_en  <= '0;
            st_q.ref_en  <= 1'b0;
            st_q.pll_en  <= '1;
            st_q.osc_en  <= 1'b1;
            st_q.core_en <= 1'b1;
            st_q.err     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_en_o     = st_q.out_en;
    assign ref_out_en_o = st_q.ref_en;
    assign pll_en_o     = st_q.pll_en;
    assign osc_en_o     = st_q.osc_en;
    assign core_en_o    = st_q.core_en;
    assign cfg_err_o    = st_q.err;
    assign sel2_o       = cfg_susp_en_i ? 1'b0 : susp_sync;
endmodule

// File: rtl/pwr_susp_ctrl_chk.sv
module pwr_susp_ctrl_chk #(
    parameter  int unsigned NUM_PLL = 3,
    parameter  int unsigned NUM_OUT = 5,
    parameter  int unsigned CNT_W   = 16,
    localparam int unsigned SRC_W   = $clog2(NUM_PLL + 1)
) (
    input logic                     clk_i,
    input logic                     rst_ni,
    input logic                     shdn_s_i,
    input logic                     susp_s_i,
    input logic                     cfg_full_shdn_i,
    input logic                     cfg_susp_en_i,
    input logic [NUM_OUT*SRC_W-1:0] cfg_src_i,
    input logic [CNT_W-1:0]         cfg_relock_i,
    input logic [NUM_OUT-1:0]       out_en_o,
    input logic                     ref_out_en_o,
    input logic [NUM_PLL-1:0]       pll_en_o,
    input logic                     osc_en_o,
    input logic                     core_en_o,
    input logic                     sel2_o
);
    logic [NUM_OUT-1:0] orphan;
    logic [NUM_PLL-1:0] on_from;

    always_comb begin
        orphan  = '0;
        on_from = '0;
        for (int o = 0; o < NUM_OUT; o++) begin
            for (int p = 0; p < NUM_PLL; p++) begin
                if (cfg_src_i[o*SRC_W +: SRC_W] == SRC_W'(p + 1)) begin
                    if (out_en_o[o] && !pll_en_o[p]) orphan[o] = 1'b1;
                    if (out_en_o[o]) on_from[p] = 1'b1;
                end
            end
        end
    end

    a_r1_all_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shdn_s_i |=> (out_en_o == '0) && !ref_out_en_o);

    a_r2_full_power_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shdn_s_i && cfg_full_shdn_i) |=> (pll_en_o == '0) && !osc_en_o && !core_en_o);

    a_r3_oe_only_keeps_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shdn_s_i && !cfg_full_shdn_i && !(cfg_susp_en_i && !susp_s_i))
        |=> (&pll_en_o) && osc_en_o && core_en_o);

    a_r5_select_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_susp_en_i |-> !sel2_o);

    a_r9_ref_follows_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shdn_s_i |=> ref_out_en_o);

    a_r11_no_orphan_output: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(cfg_src_i) |-> (orphan == '0));

    for (genvar p = 0; p < NUM_PLL; p++) begin : g_relock
        a_r7_relock_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ($rose(pll_en_o[p]) && (cfg_relock_i != '0) && $stable(cfg_relock_i)
             && $stable(cfg_src_i)) |-> !on_from[p]);
    end
endmodule

bind pwr_susp_ctrl pwr_susp_ctrl_chk #(
    .NUM_PLL (NUM_PLL),
    .NUM_OUT (NUM_OUT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .shdn_s_i        (shdn_sync),
    .susp_s_i        (susp_sync),
    .cfg_full_shdn_i (cfg_full_shdn_i),
    .cfg_susp_en_i   (cfg_susp_en_i),
    .cfg_src_i       (cfg_src_i),
    .cfg_relock_i    (cfg_relock_i),
    .out_en_o        (out_en_o),
    .ref_out_en_o    (ref_out_en_o),
    .pll_en_o        (pll_en_o),
    .osc_en_o        (osc_en_o),
    .core_en_o       (core_en_o),
    .sel2_o          (sel2_o)
);

// File: tb/pwr_susp_ctrl_tb_top.sv
module pwr_susp_ctrl_tb_top;
    localparam int unsigned NP = 3;
    localparam int unsigned NO = 5;
    localparam int unsigned CW = 16;
    localparam int unsigned NV = 12;
    // outputs 4..0 sourced from P0, reference, P2, P1, P0
    localparam logic [9:0] SRC_DEF = {2'd1, 2'd0, 2'd3, 2'd2, 2'd1};

    // stimulus {oe, susp, full, susp_en, pll_mask[3], out_mask[5]}
    // expected {out_en[5], ref, pll_en[3], osc/core, err, sel2}
    localparam logic [23:0] VEC [NV] = '{
        {1'b1,1'b1,1'b0,1'b0,3'b000,5'b00000, 5'b11111,1'b1,3'b111,1'b1,1'b0,1'b1},
        {1'b0,1'b1,1'b0,1'b0,3'b000,5'b00000, 5'b00000,1'b0,3'b111,1'b1,1'b0,1'b1},
        {1'b0,1'b1,1'b1,1'b0,3'b000,5'b00000, 5'b00000,1'b0,3'b000,1'b0,1'b0,1'b1},
        {1'b1,1'b0,1'b0,1'b0,3'b001,5'b00001, 5'b11111,1'b1,3'b111,1'b1,1'b0,1'b0},
        {1'b1,1'b0,1'b0,1'b1,3'b000,5'b01000, 5'b10111,1'b1,3'b111,1'b1,1'b0,1'b0},
        {1'b1,1'b0,1'b0,1'b1,3'b010,5'b00010, 5'b11101,1'b1,3'b101,1'b1,1'b0,1'b0},
        {1'b1,1'b0,1'b0,1'b1,3'b001,5'b00001, 5'b01110,1'b1,3'b110,1'b1,1'b1,1'b0},
        {1'b1,1'b1,1'b0,1'b1,3'b001,5'b00001, 5'b11111,1'b1,3'b111,1'b1,1'b1,1'b0},
        {1'b0,1'b0,1'b1,1'b1,3'b100,5'b00100, 5'b00000,1'b0,3'b000,1'b0,1'b0,1'b0},
        {1'b0,1'b0,1'b0,1'b1,3'b100,5'b00100, 5'b00000,1'b0,3'b011,1'b1,1'b0,1'b0},
        {1'b1,1'b1,1'b0,1'b1,3'b111,5'b00000, 5'b11111,1'b1,3'b111,1'b1,1'b1,1'b0},
        {1'b1,1'b0,1'b0,1'b1,3'b111,5'b00000, 5'b01000,1'b1,3'b000,1'b1,1'b1,1'b0}
    };

    logic          clk;
    logic          rst_n;
    logic          oe_n;
    logic          susp_n;
    logic          full;
    logic          susp_en;
    logic [NP-1:0] spll;
    logic [NO-1:0] sout;
    logic [9:0]    src;
    logic [CW-1:0] relock;
    logic [NO-1:0] out_en;
    logic          ref_en;
    logic [NP-1:0] pll_en;
    logic          osc_en;
    logic          core_en;
    logic          sel2;
    logic          err;

    int n_chk  = 0;
    int n_fail = 0;

    pwr_susp_ctrl #(.NUM_PLL(NP), .NUM_OUT(NO), .CNT_W(CW)) dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .shdn_oe_ni      (oe_n),
        .sel2_susp_ni    (susp_n),
        .cfg_full_shdn_i (full),
        .cfg_susp_en_i   (susp_en),
        .cfg_susp_pll_i  (spll),
        .cfg_susp_out_i  (sout),
        .cfg_src_i       (src),
        .cfg_relock_i    (relock),
        .out_en_o        (out_en),
        .ref_out_en_o    (ref_en),
        .pll_en_o        (pll_en),
        .osc_en_o        (osc_en),
        .core_en_o       (core_en),
        .sel2_o          (sel2),
        .cfg_err_o       (err)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; oe_n = 1'b1; susp_n = 1'b1; full = 1'b0; susp_en = 1'b0;
        spll = '0; sout = '0; src = SRC_DEF; relock = 16'd5;
        wait_neg(3);
        // R10 reset state
        chk("R10 out_en", 32'(out_en), 32'h0);
        chk("R10 ref", 32'(ref_en), 32'h0);
        chk("R10 pll_en", 32'(pll_en), 32'h7);
        chk("R10 osc/core", 32'({osc_en, core_en}), 32'h3);
        chk("R10 err", 32'(err), 32'h0);
        rst_n = 1'b1;
        wait_neg(1);
        chk("R10 first edge out_en", 32'(out_en), 32'h1f);

        // table of steady configurations
        for (int i = 0; i < int'(NV); i++) begin
            logic [23:0] v;
            v = VEC[i];
            oe_n = v[23]; susp_n = v[22]; full = v[21]; susp_en = v[20];
            spll = v[19:17]; sout = v[16:12];
            wait_neg(16);
            chk($sformatf("R1 R4 R6 vec%0d out_en", i), 32'(out_en), 32'(v[11:7]));
            chk($sformatf("R9 vec%0d ref", i), 32'(ref_en), 32'(v[6]));
            chk($sformatf("R2 R3 R4 vec%0d pll_en", i), 32'(pll_en), 32'(v[5:3]));
            chk($sformatf("R2 vec%0d osc/core", i), 32'({osc_en, core_en}), 32'({v[2], v[2]}));
            chk($sformatf("R6 vec%0d err", i), 32'(err), 32'(v[1]));
            chk($sformatf("R5 vec%0d sel2", i), 32'(sel2), 32'(v[0]));
        end

        // R6: forced mask follows the current routing (out0 moved to reference)
        src = {2'd1, 2'd0, 2'd3, 2'd2, 2'd0};
        wait_neg(4);
        chk("R6 rerouted out_en", 32'(out_en), 32'h09);
        chk("R6 rerouted err", 32'(err), 32'h1);
        src = SRC_DEF;

        // back to all running
        susp_en = 1'b0; susp_n = 1'b1; spll = '0; sout = '0; full = 1'b0; oe_n = 1'b1;
        wait_neg(16);
        chk("R4 restored out_en", 32'(out_en), 32'h1f);

        // R8: pin low reaches the outputs after the third edge
        oe_n = 1'b0;
        wait_neg(2);
        chk("R8 after edge 2", 32'(out_en), 32'h1f);
        wait_neg(1);
        chk("R8 after edge 3", 32'(out_en), 32'h00);
        chk("R3 pll kept during oe-only", 32'(pll_en), 32'h7);
        wait_neg(5);
        // R3: release without full shutdown, no relock wait
        oe_n = 1'b1;
        wait_neg(2);
        chk("R3 after edge 2", 32'(out_en), 32'h00);
        wait_neg(1);
        chk("R3 after edge 3", 32'(out_en), 32'h1f);

        // R7: full shutdown, relock of 5 cycles
        full = 1'b1; relock = 16'd5;
        oe_n = 1'b0;
        wait_neg(8);
        chk("R2 full off pll_en", 32'(pll_en), 32'h0);
        oe_n = 1'b1;
        wait_neg(3);
        chk("R7 pll back at edge 3", 32'(pll_en), 32'h7);
        chk("R7 only reference output at edge 3", 32'(out_en), 32'h08);
        chk("R9 ref back at edge 3", 32'(ref_en), 32'h1);
        wait_neg(4);
        chk("R7 still waiting at edge 7", 32'(out_en), 32'h08);
        wait_neg(1);
        chk("R7 relocked at edge 8", 32'(out_en), 32'h1f);

        // R7 boundary: zero relock wait
        relock = 16'd0;
        oe_n = 1'b0;
        wait_neg(8);
        oe_n = 1'b1;
        wait_neg(2);
        chk("R7 zero wait edge 2", 32'(out_en), 32'h00);
        wait_neg(1);
        chk("R7 zero wait edge 3", 32'(out_en), 32'h1f);
        chk("R2 osc back", 32'({osc_en, core_en}), 32'h3);

        finish_run();
    end
endmodule